// File: doc/BRIEF.md
# Capture/Reload Register with Interrupt Pin

This block holds one timer-width register that serves two roles, together with an external pin that raises interrupt requests. A capture-enable input selects the role.

When capture is enabled, each selected edge on the pin copies the current timer count into the register. When capture is disabled, selected edges only raise the request flag. The register then keeps its contents, so the timer can still reload from it. Software can also write the register directly.

The pin is asynchronous. It passes through a synchronizer chain before an edge detector. The edge detector uses a 2-bit mode field:

| Mode | Edges that count |
|------|------------------|
| 00 | none |
| 01 | rising only |
| 10 | falling only |
| 11 | both |

Each edge that counts sets a sticky request flag, which only software clears. When the interrupt enable is high, the same edge also sends a one-cycle request pulse to the interrupt controller. A reload strobe from the timer returns the register contents one cycle later, together with a one-cycle qualifier pulse.

All pins are plain single-cycle strobes or levels. The reload path has no back-pressure. The receiving timer must take the value in the cycle when `reload_pulse` is high.

Top module: `capreg_irq_top`

## Requirements
- R1: After reset, `reg_val` is 0, and `req_flag`, `irq_req` and `reload_pulse` are all low.
- R2: With `edge_sel` = 01, a rising transition on the pin sets `req_flag`, and a falling transition does not.
- R3: With `edge_sel` = 10, a falling transition on the pin sets `req_flag`, and a rising transition does not.
- R4: With `edge_sel` = 11, both rising and falling transitions set `req_flag`.
- R5: With `edge_sel` = 00, no transition sets the flag, raises `irq_req` or changes `reg_val`.
- R6: With `cap_en` = 0, a selected edge leaves `reg_val` unchanged.
- R7: With `cap_en` = 1, a selected edge loads `timer_val` into `reg_val` and also sets `req_flag`.
- R8: The pin passes through two synchronizer flops. A pin change made before clock edge 1 shows its effect at clock edge 3, and not before.
- R9: `irq_req` is a one-cycle pulse, issued in the cycle the flag is set by an edge, and only when `irq_en` is 1.
- R10: `req_flag` stays set until `flag_clr` is asserted. When an edge sets the flag and `flag_clr` is asserted in the same cycle, the flag ends up set.
- R11: `sw_wr_en` loads `sw_wr_data` into `reg_val` at the next clock. When a capture and a write occur in the same cycle, the captured timer value wins.
- R12: A `reload_stb` cycle makes `reload_pulse` high for exactly the next cycle. In that cycle, `reload_val` equals `reg_val` as it was at the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous external pin |
| cap_en | input | 1 | 1: edges capture the timer value; 0: edges only raise the flag |
| edge_sel | input | 2 | Edge mode: 00 none, 01 rising, 10 falling, 11 both |
| irq_en | input | 1 | Enables the `irq_req` pulse |
| flag_clr | input | 1 | Clears `req_flag` |
| timer_val | input | TW | Current timer count |
| sw_wr_en | input | 1 | Software write strobe for the register |
| sw_wr_data | input | TW | Software write data |
| reload_stb | input | 1 | Reload request from the timer |
| reg_val | output | TW | Register contents |
| req_flag | output | 1 | Sticky request flag |
| irq_req | output | 1 | One-cycle interrupt request |
| reload_val | output | TW | Reload value returned after a strobe |
| reload_pulse | output | 1 | Qualifies `reload_val` for one cycle |

## Verification
The bench builds the block with the default parameters: TW = 16 and SYNC_STAGES = 2.

Two synchronizer stages give a fixed three-edge latency from pin to flag, so the bench can sample exactly at the cycle before the effect and at the cycle of it. A 16-bit timer lets every case carry its own distinct timer value and preload value, so a capture cannot be mistaken for a held value.

With that configuration, the bench sweeps every combination of:
- the four edge modes,
- capture enabled and disabled,
- interrupt enabled and disabled,
- rising and falling pin transitions.

Directed cases then cover the two same-cycle priority rules and the reload strobe.

// File: rtl/capreg_pkg.sv
package capreg_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/capreg_sync.sv
module capreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/capreg_edge.sv
module capreg_edge
  import capreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  edge_mode_e mode,
  output logic       hit
);
  logic prev;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/capreg_flag.sv
module capreg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic irq_en,
  input  logic clr,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      irq <= hit & irq_en;
    end
  end
endmodule

// File: rtl/capreg_store.sv
module capreg_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         hit,
  input  logic [W-1:0] timer_val,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         reload_stb,
  output logic [W-1:0] value,
  output logic [W-1:0] reload_val,
  output logic         reload_pulse
);
  logic take_capture;

  assign take_capture = cap_en & hit;

  always_ff @(posedge clk) begin
    if (!rst_n)            value <= '0;
    else if (take_capture) value <= timer_val;
    else if (wr_en)        value <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_val   <= '0;
      reload_pulse <= 1'b0;
    end else begin
      reload_pulse <= reload_stb;
      if (reload_stb) reload_val <= value;
    end
  end
endmodule

// File: rtl/capreg_irq_top.sv
module capreg_irq_top
  import capreg_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic          cap_en,
  input  logic [1:0]    edge_sel,
  input  logic          irq_en,
  input  logic          flag_clr,
  input  logic [TW-1:0] timer_val,
  input  logic          sw_wr_en,
  input  logic [TW-1:0] sw_wr_data,
  input  logic          reload_stb,
  output logic [TW-1:0] reg_val,
  output logic          req_flag,
  output logic          irq_req,
  output logic [TW-1:0] reload_val,
  output logic          reload_pulse
);
  logic pin_sync;
  logic hit_w;

  capreg_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  capreg_edge edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(pin_sync),
    .mode(edge_mode_e'(edge_sel)), .hit(hit_w)
  );

  capreg_flag flag_i (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .irq_en(irq_en),
    .clr(flag_clr), .flag(req_flag), .irq(irq_req)
  );

  capreg_store #(.W(TW)) store_i (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .hit(hit_w),
    .timer_val(timer_val), .wr_en(sw_wr_en), .wr_data(sw_wr_data),
    .reload_stb(reload_stb), .value(reg_val),
    .reload_val(reload_val), .reload_pulse(reload_pulse)
  );
endmodule

// File: rtl/capreg_chk.sv
module capreg_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_en,
  input logic          irq_en,
  input logic          flag_clr,
  input logic          hit,
  input logic [TW-1:0] timer_val,
  input logic          sw_wr_en,
  input logic [TW-1:0] sw_wr_data,
  input logic          reload_stb,
  input logic [TW-1:0] reg_val,
  input logic          req_flag,
  input logic          irq_req,
  input logic [TW-1:0] reload_val,
  input logic          reload_pulse
);
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && hit) |=> (reg_val == $past(timer_val)) && req_flag);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cap_en && hit) && !sw_wr_en) |=> $stable(reg_val));

  assert_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && !(cap_en && hit)) |=> (reg_val == $past(sw_wr_data)));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_flag && !flag_clr) |=> req_flag);

  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (req_flag && $past(irq_en)));

  assert_reload_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reload_stb |=> (reload_pulse && reload_val == $past(reg_val)));
endmodule

bind capreg_irq_top capreg_chk #(.TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .irq_en(irq_en),
  .flag_clr(flag_clr), .hit(hit_w), .timer_val(timer_val),
  .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .reload_stb(reload_stb),
  .reg_val(reg_val), .req_flag(req_flag), .irq_req(irq_req),
  .reload_val(reload_val), .reload_pulse(reload_pulse)
);

// File: tb/capreg_irq_top_tb_top.sv
`timescale 1ns/1ps
module capreg_irq_top_tb_top;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin_in = 1'b0;
  logic          cap_en = 1'b0;
  logic [1:0]    edge_sel = 2'b00;
  logic          irq_en = 1'b0;
  logic          flag_clr = 1'b0;
  logic [TW-1:0] timer_val = '0;
  logic          sw_wr_en = 1'b0;
  logic [TW-1:0] sw_wr_data = '0;
  logic          reload_stb = 1'b0;
  logic [TW-1:0] reg_val;
  logic          req_flag;
  logic          irq_req;
  logic [TW-1:0] reload_val;
  logic          reload_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  capreg_irq_top #(.TW(TW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cap_en(cap_en),
    .edge_sel(edge_sel), .irq_en(irq_en), .flag_clr(flag_clr),
    .timer_val(timer_val), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .reload_stb(reload_stb), .reg_val(reg_val), .req_flag(req_flag),
    .irq_req(irq_req), .reload_val(reload_val), .reload_pulse(reload_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [TW-1:0] k;
    logic [TW-1:0] t;
    logic fire;
    string stag;

    nclk(3);
    rst_n = 1'b1;
    nclk(1);
    chk("R1 reg_val", 32'(reg_val), 0);
    chk("R1 req_flag", 32'(req_flag), 0);
    chk("R1 irq_req", 32'(irq_req), 0);
    chk("R1 reload_pulse", 32'(reload_pulse), 0);

    for (int sel = 0; sel < 4; sel++)
      for (int cap = 0; cap < 2; cap++)
        for (int ie = 0; ie < 2; ie++)
          for (int dir = 0; dir < 2; dir++) begin
            k = TW'(16'h1000 + sel * 64 + cap * 16 + ie * 4 + dir);
            t = TW'(16'h8000 + (sel * 8 + cap * 4 + ie * 2 + dir) * 37 + 5);
            fire = (dir == 0) ? sel[0] : sel[1];
            stag = (sel == 1) ? "R2" : (sel == 2) ? "R3" : (sel == 3) ? "R4" : "R5";

            edge_sel = 2'b00; cap_en = 1'b0; pin_in = dir[0];
            nclk(4);
            sw_wr_en = 1'b1; sw_wr_data = k; flag_clr = 1'b1;
            nclk(1);
            sw_wr_en = 1'b0; flag_clr = 1'b0;
            edge_sel = sel[1:0]; cap_en = cap[0]; irq_en = ie[0];
            timer_val = t; pin_in = ~dir[0];
            nclk(2);
            chk("R8 flag before third edge", 32'(req_flag), 0);
            nclk(1);
            chk({stag, " flag"}, 32'(req_flag), 32'(fire));
            chk(cap ? "R7 reg_val" : "R6 reg_val", 32'(reg_val),
                32'((cap != 0 && fire) ? t : k));
            chk("R9 irq pulse", 32'(irq_req), 32'(fire & ie[0]));
            nclk(1);
            chk("R9 irq one cycle", 32'(irq_req), 0);
            chk("R10 flag sticky", 32'(req_flag), 32'(fire));
          end

    edge_sel = 2'b00; cap_en = 1'b0; pin_in = 1'b0;
    nclk(4);
    sw_wr_en = 1'b1; sw_wr_data = 16'h0ABC; flag_clr = 1'b1;
    nclk(1);
    sw_wr_en = 1'b0; flag_clr = 1'b0;
    edge_sel = 2'b01; cap_en = 1'b1; irq_en = 1'b1; timer_val = 16'h5A5A;
    pin_in = 1'b1;
    nclk(2);
    flag_clr = 1'b1; sw_wr_en = 1'b1; sw_wr_data = 16'hBEEF;
    nclk(1);
    flag_clr = 1'b0; sw_wr_en = 1'b0;
    chk("R10 set beats clear", 32'(req_flag), 1);
    chk("R11 capture beats write", 32'(reg_val), 32'h5A5A);
    nclk(1);
    flag_clr = 1'b1;
    nclk(1);
    flag_clr = 1'b0;
    chk("R10 clear", 32'(req_flag), 0);
    sw_wr_en = 1'b1; sw_wr_data = 16'h1234;
    nclk(1);
    sw_wr_en = 1'b0;
    chk("R11 write", 32'(reg_val), 32'h1234);

    edge_sel = 2'b11; cap_en = 1'b0; timer_val = 16'h7777; pin_in = 1'b0;
    nclk(4);
    chk("R6 both edge no capture", 32'(reg_val), 32'h1234);
    reload_stb = 1'b1;
    nclk(1);
    reload_stb = 1'b0;
    chk("R12 reload pulse", 32'(reload_pulse), 1);
    chk("R12 reload value", 32'(reload_val), 32'h1234);
    nclk(1);
    chk("R12 pulse one cycle", 32'(reload_pulse), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule